// File: doc/BRIEF.md
# Prescaled Private Countdown Timer

A 32-bit down-counting timer for one processor core, driven through four word-wide registers on a single-cycle register port. Software sets a start value, an 8-bit tick divider and a run mode. While the timer is enabled, the count drops by one on every divided tick. When it reaches zero, a sticky status flag is raised and the interrupt line is held high until software clears it.

In one-shot mode the count stays at zero after expiry and counting stops. In auto-reload mode the start value is copied back into the count and counting goes on. Writes to the load and counter registers restart the tick phase, so the first expiry after such a write comes a predictable number of cycles later. Read data is combinational from the offset that is presented. Writes take effect on the clock edge where the write strobe is high.

Top module: `tmr_top`

## Requirements
- R1: Registers are word-addressed: offset 0x0 holds the start value, 0x4 the count, 0x8 the configuration and 0xC the status. An offset whose two low bits are not zero, or that lies outside 0x0..0xC, reads as zero, and writes to it change nothing.
- R2: In the configuration word, bit 0 is enable, bit 1 is auto-reload and bits [15:8] are the tick divider P. All other bits read back as zero.
- R3: While enabled with count N > 0, the count falls by one every P+1 clock cycles. Counted from the edge that starts counting, the count reaches zero on edge N*(P+1).
- R4: A write to 0x0 stores the value as the start value and also as the count, and it restarts the tick phase. If enabled, expiry follows V*(P+1) edges after the write edge.
- R5: A write to 0x4 replaces only the count and restarts the tick phase. The start value is kept.
- R6: The status flag is set on the edge where the count steps from 1 to 0, so `irq` is high from the next cycle on. `irq` always equals the status flag, and the flag stays set until software clears it.
- R7: With auto-reload set, expiry copies the start value into the count and counting goes on. The next expiry follows after another start*(P+1) cycles.
- R8: With auto-reload clear, the count is zero after expiry and stays zero.
- R9: A count of zero never counts down and never raises the status flag.
- R10: When enable goes from 0 to 1 while the count is zero and auto-reload is set in the same write, the start value is first copied into the count. With auto-reload clear, the count stays zero.
- R11: A read of 0x4 returns zero while the timer is disabled or the count is zero. Otherwise it returns the remaining tick count.
- R12: Writing 0xC with bit 0 set clears the status flag. Writing it with bit 0 clear has no effect. If an expiry happens in the same cycle as the clear, the flag stays set.
- R13: Reset clears the start value, the count, the configuration and the status, so all four registers read zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrite | input | 1 | Write strobe, one write per high cycle |
| busAddr | input | 4 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| irq | output | 1 | Level interrupt, equal to the status flag |

## Verification
The countdown is swept over every pairing of divider 0..3 with start value 1..4, in one-shot mode. On every cycle the bench compares the counter readback with N - floor(k/(P+1)) and measures the exact edge of expiry. This separates an error in the divider phase from an off-by-one in the count. Separate scenarios check the following: a mid-run rewrite of the load register and of the counter register, which tells a phase restart apart from a continued phase; auto-reload over two periods; a clear that lands on the expiry edge; and zero counts with and without the copy made on enable.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // word index of each register (busAddr[3:2])
  localparam logic [1:0] IDX_START = 2'd0;
  localparam logic [1:0] IDX_COUNT = 2'd1;
  localparam logic [1:0] IDX_CFG   = 2'd2;
  localparam logic [1:0] IDX_STAT  = 2'd3;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic startWr;   // write to start-value register
    logic countWr;   // write to counter register
    logic restart;   // zero the tick phase
    logic copyLoad;  // copy start value into count (enable edge)
    logic runEn;     // enable level
    logic autoRe;    // auto-reload level
  } dpCtl_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] countVal,
  input  logic [DATA_W-1:0] startVal,
  input  logic              expire,
  output dpCtl_t            dpCtl,
  output logic [PRE_W-1:0]  prescale,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  localparam int unsigned PRE_LSB = 8;
  localparam int unsigned PRE_MSB = PRE_LSB + PRE_W - 1;

  logic hiZero;
  logic hit;
  logic [1:0] sel;
  logic enQ, autoQ, statusQ;
  logic [PRE_W-1:0] preQ;
  logic cfgWr, statWr, enRise;

  generate
    if (ADDR_W > 4) begin : g_hi
      assign hiZero = (busAddr[ADDR_W-1:4] == '0);
    end else begin : g_nohi
      assign hiZero = 1'b1;
    end
  endgenerate

  assign hit    = hiZero && (busAddr[1:0] == 2'b00);
  assign sel    = busAddr[3:2];
  assign cfgWr  = busWrite && hit && (sel == IDX_CFG);
  assign statWr = busWrite && hit && (sel == IDX_STAT);
  assign enRise = cfgWr && !enQ && busWdata[0];

  always_comb begin
    dpCtl.startWr  = busWrite && hit && (sel == IDX_START);
    dpCtl.countWr  = busWrite && hit && (sel == IDX_COUNT);
    dpCtl.restart  = dpCtl.startWr || dpCtl.countWr || enRise;
    dpCtl.copyLoad = enRise && busWdata[1] && (countVal == '0);
    dpCtl.runEn    = enQ;
    dpCtl.autoRe   = autoQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      autoQ <= 1'b0;
      preQ  <= '0;
    end else if (cfgWr) begin
      enQ   <= busWdata[0];
      autoQ <= busWdata[1];
      preQ  <= busWdata[PRE_MSB:PRE_LSB];
    end
  end

  // expiry has priority over a software clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     statusQ <= 1'b0;
    else if (expire)               statusQ <= 1'b1;
    else if (statWr && busWdata[0]) statusQ <= 1'b0;
  end

  always_comb begin
    busRdata = '0;
    if (hit) begin
      unique case (sel)
        IDX_START: busRdata = startVal;
        IDX_COUNT: busRdata = enQ ? countVal : '0;
        IDX_CFG: begin
          busRdata[0]               = enQ;
          busRdata[1]               = autoQ;
          busRdata[PRE_MSB:PRE_LSB] = preQ;
        end
        IDX_STAT: busRdata[0] = statusQ;
        default: busRdata = '0;
      endcase
    end
  end

  assign prescale = preQ;
  assign irq      = statusQ;
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] countVal,
  output logic [DATA_W-1:0] startVal,
  output logic              expire
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] countQ, startQ;
  logic [PRE_W-1:0]  phaseQ;
  logic running, tick, swWr;

  assign running = dpCtl.runEn && (countQ != '0);
  assign tick    = running && (phaseQ >= prescale);
  assign swWr    = dpCtl.startWr || dpCtl.countWr;
  assign expire  = tick && (countQ == ONE) && !swWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) startQ <= '0;
    else if (dpCtl.startWr) startQ <= busWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (swWr) begin
      countQ <= busWdata;
    end else if (dpCtl.copyLoad) begin
      countQ <= startQ;
    end else if (tick) begin
      if (countQ == ONE) countQ <= dpCtl.autoRe ? startQ : '0;
      else               countQ <= countQ - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              phaseQ <= '0;
    else if (dpCtl.restart) phaseQ <= '0;
    else if (tick)          phaseQ <= '0;
    else if (running)       phaseQ <= phaseQ + PRE_W'(1);
  end

  assign countVal = countQ;
  assign startVal = startQ;
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  dpCtl_t            dpCtl;
  logic [PRE_W-1:0]  prescale;
  logic [DATA_W-1:0] countVal, startVal;
  logic              expire;

  tmr_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRE_W(PRE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .countVal(countVal), .startVal(startVal),
    .expire(expire), .dpCtl(dpCtl), .prescale(prescale),
    .busRdata(busRdata), .irq(irq)
  );

  tmr_datapath #(.DATA_W(DATA_W), .PRE_W(PRE_W)) dp_i (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .prescale(prescale),
    .busWdata(busWdata), .countVal(countVal), .startVal(startVal),
    .expire(expire)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              irq,
  input logic [DATA_W-1:0] countVal,
  input logic [DATA_W-1:0] startVal,
  input logic              enQ,
  input logic              autoQ,
  input logic              expire
);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(12);

  p_start_wr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == A_START) |=>
      (countVal == $past(busWdata) && startVal == $past(busWdata)));

  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrite && enQ && countVal > DATA_W'(1)) |=>
      (countVal == $past(countVal) || countVal == $past(countVal) - DATA_W'(1)));

  p_expire_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> irq);

  p_oneshot_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !autoQ && !busWrite) |=> countVal == '0);

  p_zero_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (countVal == '0 && !busWrite) |=> !$rose(irq));

  p_off_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == A_COUNT && !enQ) |-> busRdata == '0);

  p_clear_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == A_STAT && busWdata[0] && !expire) |=> !irq);
endmodule

bind tmr_top tmr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
  .countVal(countVal), .startVal(startVal), .enQ(dpCtl.runEn),
  .autoQ(dpCtl.autoRe), .expire(expire)
);

// File: tb/tmr_top_tb_top.sv
module tmr_top_tb_top;
  localparam logic [3:0] A_START = 4'h0, A_COUNT = 4'h4, A_CFG = 4'h8, A_STAT = 4'hC;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr_top dut_i (.clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
                 .busWdata(busWdata), .busRdata(busRdata), .irq(irq));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // write: applied on the next rising edge, returns just after it
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1 busWrite = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  // count edges from now until irq is seen high (k continues from kIn)
  task automatic runUntilIrq(input int kIn, output int k);
    k = kIn;
    busAddr = A_COUNT;
    while (k < 200) begin
      @(posedge clk); #2;
      k++;
      if (irq) break;
    end
  endtask

  initial begin
    logic [31:0] d;
    int k;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R13 reset state
    rd(A_START, d); chk(d == 0, "R13 start", d, 0);
    rd(A_COUNT, d); chk(d == 0, "R13 count", d, 0);
    rd(A_CFG, d);   chk(d == 0, "R13 cfg", d, 0);
    rd(A_STAT, d);  chk(d == 0 && irq == 0, "R13 stat", d, 0);

    // R2 field layout
    wr(A_CFG, 32'hFFFF_FFFF); rd(A_CFG, d);
    chk(d == 32'h0000_FF03, "R2 cfg readback", d, 32'h0000_FF03);
    wr(A_CFG, 0);

    // R1 misaligned offsets
    wr(A_START, 32'd9);
    wr(4'h1, 32'd77); wr(4'h6, 32'd77);
    rd(A_START, d); chk(d == 9, "R1 misaligned write ignored", d, 9);
    rd(4'h1, d);    chk(d == 0, "R1 misaligned read zero", d, 0);
    rd(4'hB, d);    chk(d == 0, "R1 misaligned read zero", d, 0);

    // R3 sweep, one-shot: also R6, R8, R11 countdown view
    for (int p = 0; p < 4; p++) begin
      for (int n = 1; n < 5; n++) begin
        int bad;
        bad = 0;
        wr(A_CFG, 0); wr(A_STAT, 1); wr(A_START, n);
        wr(A_CFG, (p << 8) | 1);
        busAddr = A_COUNT;
        k = 0;
        while (k < 100) begin
          @(posedge clk); #2;
          k++;
          if (irq) break;
          if (busRdata != 32'(n - k / (p + 1))) bad++;
        end
        chk(k == n * (p + 1), "R3 expiry edge", k, n * (p + 1));
        chk(bad == 0, "R11 countdown readback", bad, 0);
        chk(busRdata == 0, "R8 count zero after expiry", busRdata, 0);
        repeat (6) @(posedge clk);
        #2 chk(irq == 1 && busRdata == 0, "R6 sticky irq, R8 stays zero", irq, 1);
      end
    end

    // R7 auto-reload over two periods
    wr(A_CFG, 0); wr(A_STAT, 1); wr(A_START, 3);
    wr(A_CFG, 32'h0103);
    runUntilIrq(0, k);
    chk(k == 6, "R7 first expiry", k, 6);
    chk(busRdata == 3, "R7 reload value", busRdata, 3);
    wr(A_STAT, 1);
    chk(irq == 0, "R12 clear", irq, 0);
    runUntilIrq(7, k);
    chk(k == 12, "R7 second expiry", k, 12);

    // R12 clear with bit0 low ignored; expiry wins over clear
    wr(A_STAT, 32'hFFFF_FFFE);
    chk(irq == 1, "R12 bit0 low ignored", irq, 1);
    wr(A_CFG, 0); wr(A_STAT, 1); wr(A_START, 2);
    wr(A_CFG, 3);
    @(posedge clk);
    wr(A_STAT, 1);
    chk(irq == 1, "R12 expiry wins", irq, 1);
    wr(A_STAT, 1);
    chk(irq == 0, "R12 later clear", irq, 0);

    // R4 start-value rewrite mid-run restarts phase
    wr(A_CFG, 0); wr(A_STAT, 1); wr(A_START, 100);
    wr(A_CFG, 32'h0301);
    repeat (5) @(posedge clk);
    wr(A_START, 2);
    runUntilIrq(0, k);
    chk(k == 8, "R4 expiry after start write", k, 8);
    rd(A_START, d); chk(d == 2, "R4 start stored", d, 2);

    // R5 counter rewrite
    wr(A_CFG, 0); wr(A_STAT, 1); wr(A_START, 50);
    wr(A_CFG, 32'h0101);
    repeat (3) @(posedge clk);
    wr(A_COUNT, 3);
    runUntilIrq(0, k);
    chk(k == 6, "R5 expiry after count write", k, 6);
    rd(A_START, d); chk(d == 50, "R5 start kept", d, 50);

    // R9 zero count never expires
    wr(A_CFG, 0); wr(A_STAT, 1); wr(A_START, 0);
    wr(A_CFG, 3);
    repeat (20) @(posedge clk);
    #2 chk(irq == 0, "R9 no expiry at zero", irq, 0);
    rd(A_COUNT, d); chk(d == 0, "R9 count stays zero", d, 0);

    // R10 copy on enable edge
    wr(A_CFG, 0); wr(A_START, 5); wr(A_COUNT, 0);
    wr(A_CFG, 3);
    rd(A_COUNT, d); chk(d == 5, "R10 copy with auto", d, 5);
    wr(A_CFG, 0); wr(A_STAT, 1); wr(A_COUNT, 0);
    wr(A_CFG, 1);
    rd(A_COUNT, d); chk(d == 0, "R10 no copy one-shot", d, 0);
    repeat (10) @(posedge clk);
    #2 chk(irq == 0, "R10 no expiry", irq, 0);

    // R11 disabled read zero
    wr(A_CFG, 0); wr(A_COUNT, 7);
    rd(A_COUNT, d); chk(d == 0, "R11 disabled read", d, 0);
    wr(A_CFG, 32'h0F01);
    rd(A_COUNT, d); chk(d == 7, "R11 enabled read", d, 7);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule